// File: doc/BRIEF.md
# Byte-Exchange SPI Master Controller

This block is a memory-mapped SPI master that moves one byte at a time. Software sets up clock polarity, clock phase, bit order and a two-field baud prescaler through a small byte-addressed register file. It then writes a byte to the data register, which starts an exchange on SCK/MOSI. In the same exchange the block collects the byte arriving on MISO and raises a completion flag, which can also drive an interrupt line.

Software is warned of misuse in two ways. A data write made while a byte is still shifting is refused and flagged as a collision. If another device pulls the slave-select sense line low while this block is mastering the bus, the block drops out of master mode, stops the shift and raises a fault flag on its own interrupt line. Each flag clears only through a two-step access sequence. The slave-select output and the pin output enables are plain software-written port bits.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads 0x00, SCK is low and both interrupt outputs are low.
- R2: SCK rests at the CPOL level (control bit 3) whenever no exchange runs. An exchange makes exactly 16 SCK edges, each half period lasting (PRE+1)·2^RATE bus clocks, where PRE is baud bits [6:4] and RATE is baud bits [2:0].
- R3: A data write (offset 0x09) while control bits 6 and 4 are set, no fault is pending and no exchange runs starts an exchange. Status bit 7 (done) sets exactly 16·(PRE+1)·2^RATE clocks after that write.
- R4: With CPHA (control bit 2) at 0, MISO is sampled on odd SCK edges and MOSI changes on even edges. With CPHA at 1 this is reversed. Once done is set, the received byte reads back at offset 0x09.
- R5: Control bit 0 at 1 sends and assembles the byte least-significant bit first. At 0 the order is most-significant bit first.
- R6: A data write during an exchange sets status bit 6 (collision). That byte is never sent, and the running exchange completes unchanged.
- R7: Done and collision clear only when a status read (offset 0x05) that saw either flag set is followed by a data read or write. A data access without that prior status read leaves them set.
- R8: When one data write both completes the clear sequence and collides, collision stays set.
- R9: When the sense input is low while enabled as master with control bit 1 at 0, status bit 4 (fault) sets, the exchange aborts with SCK back at CPOL, and done never sets for it.
- R10: While fault is set, control bits 6 and 4 read 0, even across control writes. A status read that saw fault, followed by a control write (offset 0x00), clears fault and stores the written value.
- R11: The done interrupt output equals done AND control bit 7. The fault interrupt output equals fault AND control bit 7.
- R12: The slave-select output follows bit 3 of the port register (offset 0x0D). Bits 1, 2 and 3 of the direction register (offset 0x10) enable the MOSI, SCK and slave-select outputs.
- R13: A data write while control bit 6 or bit 4 is clear starts no exchange: SCK does not move and done stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| miso | input | 1 | Serial data in |
| ss_sense_n | input | 1 | Slave-select sense line for fault detection |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Slave-select output |
| sck_oe | output | 1 | SCK output enable |
| mosi_oe | output | 1 | MOSI output enable |
| ss_oe | output | 1 | Slave-select output enable |
| irq_done | output | 1 | Exchange-complete interrupt |
| irq_fault | output | 1 | Mode-fault interrupt |

## Verification
The clearing data access and a new collision can fall in the same cycle. That happens when software, having read status and seen collision, writes the data register again while the first byte is still shifting. The bench provokes this by writing twice during a slow exchange with a status read in between. It then expects collision to stay set, the slave to receive only the first byte, and both flags to clear only after the next proper status-then-data sequence.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL1  = 5'h00;
    localparam logic [ADDR_W-1:0] A_CTRL2  = 5'h01;
    localparam logic [ADDR_W-1:0] A_BAUD   = 5'h04;
    localparam logic [ADDR_W-1:0] A_STATUS = 5'h05;
    localparam logic [ADDR_W-1:0] A_DATA   = 5'h09;
    localparam logic [ADDR_W-1:0] A_PDATA  = 5'h0D;
    localparam logic [ADDR_W-1:0] A_PDIR   = 5'h10;

    // control bit positions
    localparam int C_IE   = 7;
    localparam int C_EN   = 6;
    localparam int C_MST  = 4;
    localparam int C_POL  = 3;
    localparam int C_PHA  = 2;
    localparam int C_SSOE = 1;
    localparam int C_LSB  = 0;

    // port / direction bit positions
    localparam int P_MOSI = 1;
    localparam int P_SCK  = 2;
    localparam int P_SS   = 3;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl1;
        logic [BYTE_W-1:0] ctrl2;
        logic [BYTE_W-1:0] baud;
        logic [BYTE_W-1:0] pdata;
        logic [BYTE_W-1:0] pdir;
        logic [BYTE_W-1:0] rxbuf;
        logic              spif;
        logic              wcol;
        logic              modf;
        logic              arm_flags;
        logic              arm_fault;
    } regs_t;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int PRE_W  = 3,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PRE_W-1:0]  pre,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = PRE_W + (1 << RATE_W);

    logic [CNT_W-1:0] cnt_d, cnt_q, half_m1;

    always_comb begin
        half_m1 = ((CNT_W'(pre) + CNT_W'(1)) << rate) - CNT_W'(1);
        tick    = run && (cnt_q == half_m1);
        cnt_d   = (!run || tick) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q <= half_m1);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic [W-1:0] tx_byte,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsbf,
    input  logic         tick,
    input  logic         miso,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_word,
    output logic         sck,
    output logic         mosi
);
    localparam int EC_W = $clog2(2 * W);
    localparam logic [EC_W-1:0] LAST = EC_W'(2 * W - 1);

    typedef struct packed {
        logic            busy;
        logic            sck;
        logic            mosi;
        logic [EC_W-1:0] edge_n;
        logic [W-1:0]    tx;
        logic [W-1:0]    rx;
    } core_t;

    core_t s_d, s_q;
    logic [W-1:0] load_v;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        for (int i = 0; i < W; i++) load_v[i] = lsbf ? tx_byte[W-1-i] : tx_byte[i];
        if (abort) begin
            s_d.busy   = 1'b0;
            s_d.sck    = 1'b0;
            s_d.edge_n = '0;
        end else if (start && !s_q.busy) begin
            s_d.busy   = 1'b1;
            s_d.sck    = 1'b0;
            s_d.edge_n = '0;
            if (!cpha) begin
                s_d.mosi = load_v[W-1];
                s_d.tx   = load_v << 1;
            end else begin
                s_d.tx   = load_v;
            end
        end else if (s_q.busy && tick) begin
            s_d.sck    = ~s_q.sck;
            s_d.edge_n = s_q.edge_n + EC_W'(1);
            if (s_q.edge_n[0] == cpha) begin
                s_d.rx = {s_q.rx[W-2:0], miso};
            end else begin
                s_d.mosi = s_q.tx[W-1];
                s_d.tx   = s_q.tx << 1;
            end
            if (s_q.edge_n == LAST) begin
                s_d.busy = 1'b0;
                done     = 1'b1;
            end
        end
        for (int i = 0; i < W; i++) rx_word[i] = lsbf ? s_d.rx[W-1-i] : s_d.rx[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign sck  = s_q.sck ^ cpol;
    assign mosi = s_q.mosi;

    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> sck == cpol);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int PRE_W  = 3,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              miso,
    input  logic              ss_sense_n,
    output logic              sck,
    output logic              mosi,
    output logic              ss_n,
    output logic              sck_oe,
    output logic              mosi_oe,
    output logic              ss_oe,
    output logic              irq_done,
    output logic              irq_fault
);
    localparam int RATE_LSB = 0;
    localparam int PRE_LSB  = 4;
    localparam logic [BYTE_W-1:0] BAUD_MASK =
        BYTE_W'(((1 << PRE_W) - 1) << PRE_LSB) | BYTE_W'((1 << RATE_W) - 1);

    regs_t r_d, r_q;
    logic rd_st, rd_dat, wr_dat, wr_c1, enabled, start, coll, fault;
    logic busy, xfer_done, tick;
    logic [BYTE_W-1:0] rx_word;

    spi_baud_gen #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .pre(r_q.baud[PRE_LSB +: PRE_W]), .rate(r_q.baud[RATE_LSB +: RATE_W]),
        .tick(tick)
    );

    spi_shift_core #(.W(BYTE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(fault),
        .tx_byte(bus_wdata), .cpol(r_q.ctrl1[C_POL]), .cpha(r_q.ctrl1[C_PHA]),
        .lsbf(r_q.ctrl1[C_LSB]), .tick(tick), .miso(miso),
        .busy(busy), .done(xfer_done), .rx_word(rx_word), .sck(sck), .mosi(mosi)
    );

    always_comb begin
        r_d     = r_q;
        rd_st   = bus_sel && !bus_wr && (bus_addr == A_STATUS);
        rd_dat  = bus_sel && !bus_wr && (bus_addr == A_DATA);
        wr_dat  = bus_sel && bus_wr && (bus_addr == A_DATA);
        wr_c1   = bus_sel && bus_wr && (bus_addr == A_CTRL1);
        enabled = r_q.ctrl1[C_EN] && r_q.ctrl1[C_MST] && !r_q.modf;
        start   = wr_dat && enabled && !busy;
        coll    = wr_dat && busy;
        fault   = !ss_sense_n && enabled && !r_q.ctrl1[C_SSOE];

        if (bus_sel && bus_wr) begin
            case (bus_addr)
                A_CTRL1: r_d.ctrl1 = bus_wdata;
                A_CTRL2: r_d.ctrl2 = bus_wdata;
                A_BAUD:  r_d.baud  = bus_wdata & BAUD_MASK;
                A_PDATA: r_d.pdata = bus_wdata;
                A_PDIR:  r_d.pdir  = bus_wdata;
                default: ;
            endcase
        end
        // first step of each clear sequence
        if (rd_st) begin
            r_d.arm_flags = r_q.spif || r_q.wcol;
            r_d.arm_fault = r_q.modf;
        end
        // second step
        if ((rd_dat || wr_dat) && r_q.arm_flags) begin
            r_d.spif      = 1'b0;
            r_d.wcol      = 1'b0;
            r_d.arm_flags = 1'b0;
        end
        if (wr_c1 && r_q.arm_fault) begin
            r_d.modf      = 1'b0;
            r_d.arm_fault = 1'b0;
        end
        // set events win over clears
        if (xfer_done) begin
            r_d.spif  = 1'b1;
            r_d.rxbuf = rx_word;
        end
        if (coll)  r_d.wcol = 1'b1;
        if (fault) r_d.modf = 1'b1;
        if (r_d.modf) begin
            r_d.ctrl1[C_EN]  = 1'b0;
            r_d.ctrl1[C_MST] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL1:  bus_rdata = r_q.ctrl1;
            A_CTRL2:  bus_rdata = r_q.ctrl2;
            A_BAUD:   bus_rdata = r_q.baud;
            A_STATUS: bus_rdata = {r_q.spif, r_q.wcol, 1'b0, r_q.modf, 4'b0000};
            A_DATA:   bus_rdata = r_q.rxbuf;
            A_PDATA:  bus_rdata = r_q.pdata;
            A_PDIR:   bus_rdata = r_q.pdir;
            default:  bus_rdata = '0;
        endcase
    end

    assign ss_n      = r_q.pdata[P_SS];
    assign mosi_oe   = r_q.pdir[P_MOSI];
    assign sck_oe    = r_q.pdir[P_SCK];
    assign ss_oe     = r_q.pdir[P_SS];
    assign irq_done  = r_q.spif && r_q.ctrl1[C_IE];
    assign irq_fault = r_q.modf && r_q.ctrl1[C_IE];

    assert_wcol_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.wcol) |-> $past(busy));
    assert_spif_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.spif) |-> $past(busy));
    assert_fault_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.modf |-> !busy);
    assert_fault_forces_R10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.modf |-> (!r_q.ctrl1[C_EN] && !r_q.ctrl1[C_MST]));
endmodule

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       miso = 1'b0, ss_sense_n = 1'b1;
    logic       sck, mosi, ss_n, sck_oe, mosi_oe, ss_oe, irq_done, irq_fault;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // slave model state
    bit         m_cpha = 0;
    logic [7:0] s_load = '0, s_sh = '0, s_in = '0;
    int         s_k = 0;
    logic [7:0] exp_q[$];
    bit         irq_prev = 0;

    always #4 clk = ~clk;

    spi_byte_master dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .miso(miso), .ss_sense_n(ss_sense_n), .sck(sck), .mosi(mosi), .ss_n(ss_n),
        .sck_oe(sck_oe), .mosi_oe(mosi_oe), .ss_oe(ss_oe),
        .irq_done(irq_done), .irq_fault(irq_fault)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
    endfunction

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic expect_reg(input logic [4:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        bus_read(a, v);
        check(v === e, req, v, e);
    endtask

    // slave: reload on select, count edges, sample or drive per phase
    always @(negedge ss_n) begin
        s_k = 0; s_in = '0; s_sh = s_load;
        if (!m_cpha) begin miso = s_sh[7]; s_sh = s_sh << 1; end
    end
    always @(sck) begin
        if (rst_n && ss_n === 1'b0) begin
            s_k++;
            if (((s_k % 2) == 1) != m_cpha) s_in = {s_in[6:0], mosi};
            else begin miso = s_sh[7]; s_sh = s_sh << 1; end
        end
    end

    // scoreboard monitor: pops on each done interrupt
    always @(negedge clk) begin
        if (irq_done && !irq_prev) begin
            if (exp_q.size() == 0) check(0, "R3 unexpected done", 1, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(s_in === e, "R4 byte seen by slave", s_in, e);
                check(s_k == 16, "R2 edge count", s_k, 16);
            end
        end
        irq_prev = irq_done;
    end

    task automatic select_slave(input logic [7:0] sl);
        bus_write(5'h0D, 8'h08);
        s_load = sl;
        bus_write(5'h0D, 8'h00);
    endtask

    // one exchange with the done interrupt enabled; leaves the flags set
    task automatic run_xfer(input bit cpol, input bit cpha, input bit lsbf,
                            input int pre, input int rate,
                            input logic [7:0] tx, input logic [7:0] sl);
        int half, n;
        half = (pre + 1) << rate;
        m_cpha = cpha;
        bus_write(5'h00, 8'hD0 | {4'b0, cpol, cpha, 1'b0, lsbf});
        bus_write(5'h04, 8'((pre << 4) | rate));
        select_slave(sl);
        check(sck === cpol, "R2 idle level before", sck, cpol);
        exp_q.push_back(lsbf ? rev8(tx) : tx);
        bus_write(5'h09, tx);
        n = 0;
        while (!irq_done && n < 20000) begin @(negedge clk); n++; end
        check(n == 16 * half, "R3 done latency", n, 16 * half);
        check(sck === cpol, "R2 idle level after", sck, cpol);
    endtask

    task automatic clear_seq(input logic [7:0] exp_rx, input string req);
        expect_reg(5'h05, 8'h80, "R3 done flag");
        expect_reg(5'h09, exp_rx, req);
        expect_reg(5'h05, 8'h00, "R7 cleared by sequence");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check(sck === 1'b0 && irq_done === 1'b0 && irq_fault === 1'b0, "R1 outputs", sck, 0);
        expect_reg(5'h00, 8'h00, "R1 ctrl");
        expect_reg(5'h04, 8'h00, "R1 baud");
        expect_reg(5'h05, 8'h00, "R1 status");
        expect_reg(5'h09, 8'h00, "R1 data");
        expect_reg(5'h10, 8'h00, "R1 dir");

        // R12 port pins
        bus_write(5'h10, 8'h0E);
        check({mosi_oe, sck_oe, ss_oe} === 3'b111, "R12 enables", {mosi_oe, sck_oe, ss_oe}, 7);
        bus_write(5'h0D, 8'h08);
        check(ss_n === 1'b1, "R12 ss high", ss_n, 1);
        bus_write(5'h0D, 8'h00);
        check(ss_n === 1'b0, "R12 ss low", ss_n, 0);
        bus_write(5'h10, 8'h04);
        check({mosi_oe, sck_oe, ss_oe} === 3'b010, "R12 sck only", {mosi_oe, sck_oe, ss_oe}, 2);
        bus_write(5'h10, 8'h0E);

        // main function across modes, orders and rates (R2 R3 R4 R5)
        run_xfer(0, 0, 0, 0, 0, 8'hA5, 8'h3C); clear_seq(8'h3C, "R4 mode0 rx");
        run_xfer(1, 0, 0, 2, 1, 8'h81, 8'hE7); clear_seq(8'hE7, "R4 cpol1 rx");
        run_xfer(0, 1, 0, 1, 0, 8'h5A, 8'h96); clear_seq(8'h96, "R4 cpha1 rx");
        run_xfer(1, 1, 1, 0, 2, 8'h1F, 8'hC4); clear_seq(rev8(8'hC4), "R5 lsb rx");
        run_xfer(0, 0, 1, 7, 0, 8'h02, 8'h40); clear_seq(rev8(8'h40), "R5 lsb mode0 rx");
        expect_reg(5'h04, 8'h70, "R2 baud readback");

        // R7 data read without status read leaves done set
        run_xfer(0, 0, 0, 0, 1, 8'h33, 8'hCC);
        expect_reg(5'h09, 8'hCC, "R7 data");
        expect_reg(5'h05, 8'h80, "R7 still set");
        expect_reg(5'h09, 8'hCC, "R7 data again");
        expect_reg(5'h05, 8'h00, "R7 cleared");

        // R6 / R8 collision and same-cycle clear
        m_cpha = 0;
        bus_write(5'h00, 8'hD0);
        bus_write(5'h04, 8'h02);
        select_slave(8'h69);
        exp_q.push_back(8'hA5);
        bus_write(5'h09, 8'hA5);
        bus_write(5'h09, 8'h11);
        expect_reg(5'h05, 8'h40, "R6 collision flag");
        bus_write(5'h09, 8'h22);
        expect_reg(5'h05, 8'h40, "R8 collision kept");
        while (!irq_done) @(negedge clk);
        @(negedge clk);
        expect_reg(5'h05, 8'hC0, "R6 both flags");
        expect_reg(5'h09, 8'h69, "R6 rx unaffected");
        expect_reg(5'h05, 8'h00, "R7 both cleared");

        // R11 no done interrupt with enable bit clear
        bus_write(5'h00, 8'h50);
        select_slave(8'h0F);
        bus_write(5'h09, 8'hF0);
        repeat (70) @(negedge clk);
        check(irq_done === 1'b0, "R11 irq masked", irq_done, 0);
        check(s_in === 8'hF0, "R4 masked xfer tx", s_in, 8'hF0);
        expect_reg(5'h05, 8'h80, "R11 flag set");
        expect_reg(5'h09, 8'h0F, "R11 rx");

        // R13 disabled: no exchange
        bus_write(5'h00, 8'h90);
        select_slave(8'h00);
        bus_write(5'h09, 8'h55);
        repeat (80) @(negedge clk);
        check(s_k == 0 && sck === 1'b0, "R13 no edges", s_k, 0);
        expect_reg(5'h05, 8'h00, "R13 no done");

        // R9 / R10 mode fault
        bus_write(5'h00, 8'hD0);
        bus_write(5'h04, 8'h03);
        select_slave(8'hAA);
        bus_write(5'h09, 8'h77);
        repeat (20) @(negedge clk);
        ss_sense_n = 0;
        @(negedge clk);
        ss_sense_n = 1;
        check(sck === 1'b0, "R9 sck idle", sck, 0);
        check(irq_fault === 1'b1, "R11 fault irq", irq_fault, 1);
        expect_reg(5'h00, 8'h80, "R10 bits forced");
        bus_write(5'h00, 8'hD0);
        expect_reg(5'h00, 8'h80, "R10 write held");
        repeat (200) @(negedge clk);
        check(irq_done === 1'b0, "R9 no done", irq_done, 0);
        expect_reg(5'h05, 8'h10, "R9 fault flag");
        bus_write(5'h00, 8'hD0);
        expect_reg(5'h00, 8'hD0, "R10 released");
        expect_reg(5'h05, 8'h00, "R10 fault cleared");
        check(irq_fault === 1'b0, "R11 fault irq low", irq_fault, 0);
        check(exp_q.size() == 0, "R3 all done seen", exp_q.size(), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule